// File: doc/BRIEF.md
# Single-Error-Correcting Protected Register

This block holds one data or configuration word in a flip-flop register. On the way in, combinational logic adds Hamming parity bits. The word and its parity are stored together as one codeword. On the way out, combinational logic recomputes the syndrome on every cycle. It flips back any single corrupted bit before the value reaches the read port, and it raises a flag while it does so.

The stored codeword is checked continuously, not only when it is read. When an upset is found and no write is pending, the repaired codeword goes back into the register on the next clock edge. A single upset therefore cannot sit there until a second one arrives and turns it into an uncorrectable pair.

Upsets are assumed to last less than a clock period, so they reach only the register and never the combinational paths. Errors in more than one bit are not corrected.

Top module: `hreg_protected_reg`

## Requirements
- R1: While `rst_n` is low, `code_q` is all zeros, `rd_data` is zero and `corr_flag` is low.
- R2: A rising clock edge with `wr_en` high stores the codeword of `wr_data`. Codeword positions run from 1 up to the codeword width, and position p is `code_q[p-1]`. Data bit i goes to the i-th position, in ascending order, whose index is not a power of two (3, 5, 6, 7, 9, 10, 11 at the default width). Positions 1, 2, 4 and 8 each hold the even parity of every other position whose index has that bit set. After the edge, `rd_data` equals the written word.
- R3: With `wr_en` low and no upset in the register, `code_q` and `rd_data` keep their values whatever `wr_data` does.
- R4: If exactly one bit of the stored codeword is inverted, at any position, then in that same cycle `rd_data` still shows the stored word and `corr_flag` is high.
- R5: At the first clock edge after such an upset, with `wr_en` low, the register takes the repaired codeword. `code_q` then returns to its clean value and `corr_flag` goes low, so the flag lasts one cycle per upset.
- R6: If `wr_en` is high in a cycle where an upset is present, the new write data is stored and the repair is dropped.
- R7: If the syndrome names a position beyond the codeword width, nothing is corrected. `corr_flag` stays low, `rd_data` is taken from the raw data positions and `code_q` is left unchanged at the next edge. At the default width this happens when positions 4 and 8 are both inverted, which gives syndrome 12.
- R8: The number of parity bits is the smallest P with 2^P at least `DATA_W`+P+1. For any `DATA_W` from 5 to 11 this is 4, so the default `code_q` is 11 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store `wr_data` at the next edge |
| wr_data | input | DATA_W | Word to be stored |
| rd_data | output | DATA_W | Corrected stored word |
| corr_flag | output | 1 | High while a single-bit repair is being applied |
| code_q | output | DATA_W+P | Raw stored codeword, position p at bit p-1 |

## Verification
The bench inverts every codeword position in turn, parity positions included. A decoder with one wrong coverage mask would then hand back a damaged word or flag the wrong bit. Each upset is followed by a look at the raw codeword after the next edge. A design without write-back would still show the flipped bit there, and one that writes back every cycle would show it lingering or changing. A write issued during an upset must win, or the old word would return. A double upset whose syndrome points past the last position must be left alone, because a design that masks only the low bits of the syndrome would corrupt a data bit and raise the flag.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    // smallest parity count that can name every codeword position plus "no error"
    function automatic int parity_count(input int data_w);
        for (int p = 1; p < 31; p++) begin
            if ((1 << p) >= data_w + p + 1) return p;
        end
        return 31;
    endfunction

    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

    // 1-based codeword position of data bit idx
    function automatic int data_slot(input int idx);
        int seen;
        seen = 0;
        for (int pos = 1; pos < 64; pos++) begin
            if (!is_pow2(pos)) begin
                if (seen == idx) return pos;
                seen++;
            end
        end
        return 0;
    endfunction

    // data bit index held at a non-power-of-two position
    function automatic int slot_index(input int pos);
        int seen;
        seen = 0;
        for (int q = 1; q < pos; q++) begin
            if (!is_pow2(q)) seen++;
        end
        return seen;
    endfunction

    // positions (bit pos-1) whose index has bit j set
    function automatic logic [63:0] cover_mask(input int j);
        logic [63:0] m;
        m = '0;
        for (int pos = 1; pos <= 64; pos++) begin
            m[pos-1] = ((pos >> j) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/hreg_encoder.sv
module hreg_encoder
    import hreg_pkg::*;
#(
    parameter int DATA_W = 7
) (
    input  logic [DATA_W-1:0]                       data_i,
    output logic [DATA_W+parity_count(DATA_W)-1:0]  cw_o
);
    localparam int P  = parity_count(DATA_W);
    localparam int CW = DATA_W + P;

    logic [CW-1:0] placed;
    logic [P-1:0]  parity;

    // data bits at their slots, zeros where parity will go
    for (genvar pos = 1; pos <= CW; pos++) begin : g_place
        if (is_pow2(pos)) begin : g_hole
            assign placed[pos-1] = 1'b0;
        end else begin : g_bit
            assign placed[pos-1] = data_i[slot_index(pos)];
        end
    end

    for (genvar j = 0; j < P; j++) begin : g_par
        localparam logic [63:0] MASK_FULL = cover_mask(j);
        assign parity[j] = ^(placed & MASK_FULL[CW-1:0]);
    end

    for (genvar pos = 1; pos <= CW; pos++) begin : g_out
        if (is_pow2(pos)) begin : g_p
            assign cw_o[pos-1] = parity[$clog2(pos)];
        end else begin : g_d
            assign cw_o[pos-1] = placed[pos-1];
        end
    end

endmodule

// File: rtl/hreg_decoder.sv
module hreg_decoder
    import hreg_pkg::*;
#(
    parameter int DATA_W = 7
) (
    input  logic [DATA_W+parity_count(DATA_W)-1:0]  cw_i,
    output logic [DATA_W+parity_count(DATA_W)-1:0]  fixed_o,
    output logic [DATA_W-1:0]                       data_o,
    output logic                                    hit_o
);
    localparam int P  = parity_count(DATA_W);
    localparam int CW = DATA_W + P;
    localparam logic [P-1:0] LAST_POS = P'(CW);

    logic [P-1:0]  syn;
    logic [CW-1:0] flip;
    logic          in_range;

    for (genvar j = 0; j < P; j++) begin : g_syn
        localparam logic [63:0] MASK_FULL = cover_mask(j);
        assign syn[j] = ^(cw_i & MASK_FULL[CW-1:0]);
    end

    // a syndrome past the last position means more than one bit is bad
    assign in_range = (syn != '0) && (syn <= LAST_POS);
    assign hit_o    = in_range;

    for (genvar pos = 1; pos <= CW; pos++) begin : g_flip
        assign flip[pos-1] = in_range && (syn == P'(pos));
    end

    assign fixed_o = cw_i ^ flip;

    for (genvar i = 0; i < DATA_W; i++) begin : g_extract
        assign data_o[i] = fixed_o[data_slot(i)-1];
    end

endmodule

// File: rtl/hreg_store.sv
module hreg_store #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [CW-1:0] enc_cw_i,
    input  logic          hit_i,
    input  logic [CW-1:0] fixed_cw_i,
    output logic [CW-1:0] cw_o
);
    typedef struct packed {
        logic [CW-1:0] cw;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.cw = enc_cw_i;
        end else if (hit_i) begin
            state_d.cw = fixed_cw_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cw_o = state_q.cw;

endmodule

// File: rtl/hreg_protected_reg.sv
module hreg_protected_reg
    import hreg_pkg::*;
#(
    parameter int DATA_W = 7
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic [DATA_W-1:0]                       wr_data,
    output logic [DATA_W-1:0]                       rd_data,
    output logic                                    corr_flag,
    output logic [DATA_W+parity_count(DATA_W)-1:0]  code_q
);
    localparam int P  = parity_count(DATA_W);
    localparam int CW = DATA_W + P;

    logic [CW-1:0] enc_cw;
    logic [CW-1:0] fixed_cw;
    logic [CW-1:0] stored_cw;
    logic          hit;

    hreg_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i (wr_data),
        .cw_o   (enc_cw)
    );

    hreg_store #(.CW(CW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .enc_cw_i   (enc_cw),
        .hit_i      (hit),
        .fixed_cw_i (fixed_cw),
        .cw_o       (stored_cw)
    );

    hreg_decoder #(.DATA_W(DATA_W)) u_dec (
        .cw_i    (stored_cw),
        .fixed_o (fixed_cw),
        .data_o  (rd_data),
        .hit_o   (hit)
    );

    assign corr_flag = hit;
    assign code_q    = stored_cw;

endmodule

// File: rtl/hreg_protected_reg_chk.sv
module hreg_protected_reg_chk #(
    parameter int DATA_W = 7,
    parameter int CW     = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              corr_flag,
    input logic [CW-1:0]     code_q
);
    // R1: register cleared while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (code_q == '0 && !corr_flag && rd_data == '0);
        end
    end

    // R2: a write shows up on the read port (unless an upset has since appeared)
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (corr_flag || rd_data == $past(wr_data)));

    // R3: without a write the corrected read value does not move
    a_r3_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    // R5: a repair clears the flag after one edge
    a_r5_flag_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_flag && !wr_en) |=> !corr_flag);

endmodule

bind hreg_protected_reg hreg_protected_reg_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .corr_flag (corr_flag),
    .code_q    (code_q)
);

// File: tb/hreg_protected_reg_tb_top.sv
`timescale 1ns/1ps
module hreg_protected_reg_tb_top;
    localparam int DW = 7;
    localparam int CWB = 11;
    localparam int NVEC = 8;

    // {data, expected codeword} worked out by hand from R2
    localparam logic [DW+CWB-1:0] VEC [NVEC] = '{
        {7'h00, 11'h000},
        {7'h7F, 11'h7FF},
        {7'h01, 11'h007},
        {7'h40, 11'h483},
        {7'h55, 11'h52F},
        {7'h2A, 11'h2D0},
        {7'h0F, 11'h07F},
        {7'h70, 11'h780}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           wr_en;
    logic [DW-1:0]  wr_data;
    logic [DW-1:0]  rd_data;
    logic           corr_flag;
    logic [CWB-1:0] code_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hreg_protected_reg #(.DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .corr_flag (corr_flag),
        .code_q    (code_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_word(input logic [DW-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic upset(input logic [CWB-1:0] v);
        force dut_i.u_store.state_q = v;
        #1;
        release dut_i.u_store.state_q;
        #1;
    endtask

    initial begin
        rst_n   = 1'b1;
        wr_en   = 1'b0;
        wr_data = '0;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "code_q", 32'(code_q), 32'h0);
        chk("R1", "rd_data", 32'(rd_data), 32'h0);
        chk("R1", "corr_flag", 32'(corr_flag), 32'h0);
        chk("R8", "codeword width", 32'($bits(code_q)), 32'd11);
        rst_n = 1'b1;

        // R2: encoding table
        for (int i = 0; i < NVEC; i++) begin
            write_word(VEC[i][DW+CWB-1:CWB]);
            chk("R2", "code_q", 32'(code_q), 32'(VEC[i][CWB-1:0]));
            chk("R2", "rd_data", 32'(rd_data), 32'(VEC[i][DW+CWB-1:CWB]));
            chk("R2", "corr_flag", 32'(corr_flag), 32'h0);
        end

        // R3: hold while wr_data moves
        wr_data = 7'h2A;
        repeat (3) @(negedge clk);
        chk("R3", "code_q", 32'(code_q), 32'h780);
        chk("R3", "rd_data", 32'(rd_data), 32'h70);

        // R4 / R5: every position flipped in turn
        write_word(7'h55);
        for (int k = 0; k < CWB; k++) begin
            @(negedge clk);
            upset(11'h52F ^ (11'h1 << k));
            chk("R4", "rd_data", 32'(rd_data), 32'h55);
            chk("R4", "corr_flag", 32'(corr_flag), 32'h1);
            chk("R4", "code_q flipped", 32'(code_q), 32'(11'h52F ^ (11'h1 << k)));
            @(negedge clk);
            chk("R5", "code_q restored", 32'(code_q), 32'h52F);
            chk("R5", "corr_flag", 32'(corr_flag), 32'h0);
            chk("R5", "rd_data", 32'(rd_data), 32'h55);
        end

        // R6: write during an upset wins
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 7'h2A;
        upset(11'h52F ^ 11'h004);
        chk("R6", "corr_flag", 32'(corr_flag), 32'h1);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6", "code_q", 32'(code_q), 32'h2D0);
        chk("R6", "rd_data", 32'(rd_data), 32'h2A);

        // R7: syndrome 12 left alone
        write_word(7'h55);
        @(negedge clk);
        upset(11'h52F ^ 11'h088);
        chk("R7", "corr_flag", 32'(corr_flag), 32'h0);
        chk("R7", "rd_data", 32'(rd_data), 32'h55);
        @(negedge clk);
        chk("R7", "code_q unchanged", 32'(code_q), 32'h5A7);
        write_word(7'h0F);
        chk("R2", "code_q after recovery write", 32'(code_q), 32'h07F);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "code_q mid-run", 32'(code_q), 32'h0);
        chk("R1", "rd_data mid-run", 32'(rd_data), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "code_q after release", 32'(code_q), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule